// File: doc/BRIEF.md
# Binary32 to Binary16 Narrowing Converter

This block narrows an IEEE binary32 operand to IEEE binary16 under a rounding mode chosen per operation. Every class of input is handled: results that land in the normal half range, results that become half subnormals, values too small for any half (flushed to signed zero or lifted to the smallest subnormal), values too large (saturated to infinity or to the largest finite half, depending on mode and sign), infinities, and NaNs, which always leave as quiet NaNs.

A datapath feeds one operand and a 3-bit mode per cycle with a valid strobe. With the output register enabled (the default) the result and its valid appear one clock later. With it disabled the path is purely combinational. No flags are produced.

Top module: `fp_narrow_32to16`

## Requirements
- R1: Mode encoding on `in_mode`: 0 rounds toward +infinity, 1 toward -infinity, 2 toward zero, 3 to nearest with ties to even, 4 to nearest with ties away from zero. Codes 5, 6 and 7 behave exactly as code 3.
- R2: An operand with biased exponent 113..142 yields a half whose exponent field is the operand exponent minus 112 and whose fraction is the top 10 of the 23 operand fraction bits, after rounding on the 13 dropped bits. A rounding carry may raise the exponent, up to infinity (0x7C00 magnitude).
- R3: Ties-to-even (mode 3) rounds up when the dropped part is above half a unit in the last place, or exactly half with the kept LSB odd. Otherwise it truncates.
- R4: Ties-away (mode 4) rounds the magnitude up whenever the dropped part is at least half a unit in the last place.
- R5: Mode 0 rounds the magnitude of positive values up on any nonzero dropped part, and truncates negatives. Mode 1 does the reverse. Mode 2 always truncates the magnitude.
- R6: A finite operand with exponent 143..254 saturates. A positive value gives 0x7C00 in modes 0, 3 and 4, and 0x7BFF in modes 1 and 2. A negative value gives 0xFC00 in modes 1, 3 and 4, and 0xFBFF in modes 0 and 2.
- R7: An operand with exponent 102..112 yields a subnormal half. The significand with its hidden one restored is shifted right by 126 minus the exponent, and the mode's rounding is applied to the shifted-out bits. A carry may reach the smallest normal (0x0400 magnitude).
- R8: An operand with exponent below 102 gives signed zero. The two exceptions give the smallest subnormal: a nonzero positive operand in mode 0 gives 0x0001, and a nonzero negative operand in mode 1 gives 0x8001.
- R9: Exponent 255 with a zero fraction gives infinity of the same sign. With a nonzero fraction it gives exponent field 0x1F, fraction bit 9 set, and fraction bits 8..0 taken from operand bits 21..13.
- R10: Output bit 15 always equals operand bit 31, including zero and NaN results.
- R11: With the output register enabled, `out_valid` follows `in_valid` by exactly one clock and `out_res` holds the result of the operand accepted on that edge. Synchronous reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| in_op | input | 32 | Binary32 operand |
| in_mode | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result valid |
| out_res | output | 16 | Binary16 result |

## Verification
The bench aims at the places where narrowing goes wrong. One is the largest-finite tie that must carry into infinity, where a design that clips the carry would return 0x7BFF. Others are exact ties at the kept LSB, where an even/odd confusion shifts the result by one unit, and the boundary exponents 101, 102, 112 and 113, where an off-by-one shift amount halves or doubles subnormals. It also checks the sign-dependent saturation and tiny-value cases, where swapping the direction of modes 0 and 1 flips 0x7C00/0x7BFF or 0x0000/0x0001, and NaNs carrying only low payload bits, which an unquieted path would turn into infinity. Random operands in all eight mode codes are compared with an independently written remainder-versus-half model.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  localparam int SP_W     = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int HP_W     = 16;
  localparam int HP_EXP_W = 5;
  localparam int HP_MAN_W = 10;
  localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
  localparam int HP_BIAS  = (1 << (HP_EXP_W - 1)) - 1;
  localparam int SIG_W    = SP_MAN_W + 1;
  localparam int DROP_W   = SP_MAN_W - HP_MAN_W;
  localparam int NORM_MIN = SP_BIAS - HP_BIAS + 1;
  localparam int NORM_MAX = SP_BIAS + HP_BIAS;
  localparam int SUB_MIN  = NORM_MIN - HP_MAN_W - 1;
  localparam int MAG_W    = HP_W - 1;

  typedef enum logic [2:0] {
    RM_POS_INF = 3'd0,
    RM_NEG_INF = 3'd1,
    RM_ZERO    = 3'd2,
    RM_EVEN    = 3'd3,
    RM_AWAY    = 3'd4
  } rmode_e;

  typedef enum logic [2:0] {
    CL_TINY, CL_SUB, CL_NORM, CL_OVF, CL_INF, CL_NAN
  } cls_e;

  typedef struct packed {
    logic                sign;
    cls_e                cls;
    logic                nonzero;
    logic [MAG_W-1:0]    kept;
    logic                guard;
    logic                sticky;
    logic [HP_MAN_W-1:0] payload;
  } dec_t;

  function automatic logic dir_away(rmode_e m, logic s);
    return (m == RM_POS_INF && !s) || (m == RM_NEG_INF && s);
  endfunction
endpackage

// File: rtl/fpn_unpack.sv
module fpn_unpack
  import fpn_pkg::*;
(
  input  logic [SP_W-1:0] op,
  output dec_t            dec
);
  localparam int SUBW = HP_MAN_W + SIG_W;

  logic [SP_EXP_W-1:0] ex;
  logic [SP_MAN_W-1:0] fr;
  logic [SP_EXP_W-1:0] sub_sh;
  logic [SUBW-1:0]     sub_w;
  logic [HP_EXP_W-1:0] nexp;

  assign ex     = op[SP_W-2 -: SP_EXP_W];
  assign fr     = op[SP_MAN_W-1:0];
  assign sub_sh = SP_EXP_W'(NORM_MIN - 1) - ex;
  assign sub_w  = {1'b1, fr, {HP_MAN_W{1'b0}}} >> sub_sh;
  assign nexp   = HP_EXP_W'(ex - SP_EXP_W'(NORM_MIN - 1));

  always_comb begin
    dec         = '0;
    dec.sign    = op[SP_W-1];
    dec.nonzero = |op[SP_W-2:0];
    dec.payload = fr[SP_MAN_W-1 -: HP_MAN_W];
    if (ex == {SP_EXP_W{1'b1}})
      dec.cls = (fr != '0) ? CL_NAN : CL_INF;
    else if (int'(ex) > NORM_MAX)
      dec.cls = CL_OVF;
    else if (int'(ex) >= NORM_MIN)
      dec.cls = CL_NORM;
    else if (int'(ex) >= SUB_MIN)
      dec.cls = CL_SUB;
    else
      dec.cls = CL_TINY;

    if (dec.cls == CL_SUB) begin
      dec.kept   = {{HP_EXP_W{1'b0}}, sub_w[SUBW-1 -: HP_MAN_W]};
      dec.guard  = sub_w[SIG_W-1];
      dec.sticky = |sub_w[SIG_W-2:0];
    end else begin
      dec.kept   = {nexp, fr[SP_MAN_W-1 -: HP_MAN_W]};
      dec.guard  = fr[DROP_W-1];
      dec.sticky = |fr[DROP_W-2:0];
    end
  end
endmodule

// File: rtl/fpn_round.sv
module fpn_round
  import fpn_pkg::*;
(
  input  rmode_e           mode,
  input  logic             sign,
  input  logic [MAG_W-1:0] kept,
  input  logic             guard,
  input  logic             sticky,
  output logic [MAG_W-1:0] mag
);
  logic up;

  always_comb begin
    unique case (mode)
      RM_POS_INF, RM_NEG_INF: up = dir_away(mode, sign) && (guard || sticky);
      RM_ZERO:                up = 1'b0;
      RM_AWAY:                up = guard;
      default:                up = guard && (sticky || kept[0]);
    endcase
  end

  assign mag = kept + MAG_W'(up);
endmodule

// File: rtl/fpn_pack.sv
module fpn_pack
  import fpn_pkg::*;
(
  input  dec_t             dec,
  input  rmode_e           mode,
  input  logic [MAG_W-1:0] mag,
  output logic [HP_W-1:0]  res
);
  localparam logic [MAG_W-1:0] MAG_INF = {{HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAG_MAX = MAG_INF - 1'b1;
  localparam logic [HP_MAN_W-1:0] QBIT = 1'b1 << (HP_MAN_W - 1);

  logic to_inf;
  logic lift;

  assign to_inf = (mode == RM_EVEN) || (mode == RM_AWAY) || dir_away(mode, dec.sign);
  assign lift   = dec.nonzero && dir_away(mode, dec.sign);

  always_comb begin
    unique case (dec.cls)
      CL_NAN:  res = {dec.sign, {HP_EXP_W{1'b1}}, dec.payload | QBIT};
      CL_INF:  res = {dec.sign, MAG_INF};
      CL_OVF:  res = {dec.sign, to_inf ? MAG_INF : MAG_MAX};
      CL_TINY: res = {dec.sign, {(MAG_W-1){1'b0}}, lift};
      default: res = {dec.sign, mag};
    endcase
  end
endmodule

// File: rtl/fp_narrow_32to16.sv
module fp_narrow_32to16
  import fpn_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_op,
  input  logic [2:0]      in_mode,
  output logic            out_valid,
  output logic [HP_W-1:0] out_res
);
  rmode_e           mode;
  dec_t             dec;
  logic [MAG_W-1:0] mag;
  logic [HP_W-1:0]  res;

  assign mode = (in_mode > 3'd4) ? RM_EVEN : rmode_e'(in_mode);

  fpn_unpack u_unpack (.op(in_op), .dec(dec));

  fpn_round u_round (
    .mode(mode), .sign(dec.sign), .kept(dec.kept),
    .guard(dec.guard), .sticky(dec.sticky), .mag(mag)
  );

  fpn_pack u_pack (.dec(dec), .mode(mode), .mag(mag), .res(res));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_res   <= '0;
        end else begin
          out_valid <= in_valid;
          out_res   <= res;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_res   = res;
    end
  endgenerate
endmodule

// File: rtl/fpn_narrow_chk.sv
module fpn_narrow_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic [2:0]  in_mode,
  input logic        out_valid,
  input logic [15:0] out_res
);
  logic [7:0] ex;
  assign ex = in_op[30:23];

  generate
    if (REG_OUT) begin : g_chk
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11
      AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R11
      AST_SIGN_COPY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_res[15] == $past(in_op[31])); // R10
      AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex == 8'hFF && in_op[22:0] != 23'd0) |=> out_res[14:9] == 6'h3F); // R9
      AST_OVF_SAT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex > 8'd142 && ex != 8'hFF) |=>
        (out_res[14:0] == 15'h7C00 || out_res[14:0] == 15'h7BFF)); // R6
      AST_TINY_TRUNC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex < 8'd102 && in_mode == 3'd2) |=> out_res[14:0] == 15'd0); // R8
    end
  endgenerate
endmodule

bind fp_narrow_32to16 fpn_narrow_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/fp_narrow_32to16_bench.sv
`timescale 1ns/1ps
module fp_narrow_32to16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic [15:0] out_res;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fp_narrow_32to16 u_fp_narrow_32to16 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_mode(in_mode), .out_valid(out_valid), .out_res(out_res)
  );

  function automatic logic [15:0] ref_cvt(logic [31:0] op, logic [2:0] md);
    logic s;
    int e, sh, md2;
    longint sig, kept, rem, half, mag;
    bit away, up;
    s = op[31];
    e = int'(op[30:23]);
    md2 = (md > 3'd4) ? 3 : int'(md);
    away = (md2 == 0 && !s) || (md2 == 1 && s);
    if (e == 255)
      return (op[22:0] != 0) ? {s, 5'h1F, 1'b1, op[21:13]} : {s, 15'h7C00};
    if (e > 142)
      return (md2 == 2 || (md2 == 0 && s) || (md2 == 1 && !s)) ? {s, 15'h7BFF} : {s, 15'h7C00};
    if (e < 102)
      return {s, 14'd0, (op[30:0] != 0) && away};
    sh   = (e >= 113) ? 13 : 126 - e;
    sig  = longint'({1'b1, op[22:0]});
    kept = sig >> sh;
    rem  = sig - (kept << sh);
    half = longint'(1) << (sh - 1);
    case (md2)
      0, 1:    up = away && rem != 0;
      2:       up = 0;
      4:       up = rem >= half;
      default: up = rem > half || (rem == half && kept[0]);
    endcase
    mag = kept + longint'(up);
    if (e >= 113) mag = mag + longint'((e - 113) << 10);
    return {s, mag[14:0]};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(logic [31:0] op, logic [2:0] md, logic [15:0] expv, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_mode  = md;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R11: actual unexpected valid expected none");
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_res, e);
      end
    end
  end

  function automatic string tag_of(logic [31:0] op, logic [2:0] md);
    int e;
    e = int'(op[30:23]);
    if (md > 3'd4) return "R1";
    if (e == 255) return "R9";
    if (e > 142) return "R6";
    if (e >= 113) return "R2";
    if (e >= 102) return "R7";
    return "R8";
  endfunction

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", {15'd0, out_valid}, 16'd0);
    check("R11", out_res, 16'h0000);
    rst = 1'b0;
    in_valid = 1'b0;
    idle();

    // R2 / R10 basic normals
    send(32'h3F800000, 3'd3, 16'h3C00, "R2");
    send(32'hBF800000, 3'd3, 16'hBC00, "R10");
    send(32'h477FE000, 3'd2, 16'h7BFF, "R2");
    send(32'h477FF000, 3'd3, 16'h7C00, "R2");
    send(32'h477FF000, 3'd2, 16'h7BFF, "R2");
    // R3 ties to even
    send(32'h3F801000, 3'd3, 16'h3C00, "R3");
    send(32'h3F803000, 3'd3, 16'h3C02, "R3");
    send(32'h3F801001, 3'd3, 16'h3C01, "R3");
    // R4 ties away
    send(32'h3F801000, 3'd4, 16'h3C01, "R4");
    // R5 directed
    send(32'hBF800001, 3'd0, 16'hBC00, "R5");
    send(32'hBF800001, 3'd1, 16'hBC01, "R5");
    send(32'h3F800001, 3'd0, 16'h3C01, "R5");
    send(32'h3F800001, 3'd1, 16'h3C00, "R5");
    send(32'h3F801FFF, 3'd2, 16'h3C00, "R5");
    idle();
    // R6 overflow
    send(32'h47C35000, 3'd0, 16'h7C00, "R6");
    send(32'h47C35000, 3'd1, 16'h7BFF, "R6");
    send(32'h47C35000, 3'd2, 16'h7BFF, "R6");
    send(32'h47C35000, 3'd3, 16'h7C00, "R6");
    send(32'h47C35000, 3'd4, 16'h7C00, "R6");
    send(32'hC7C35000, 3'd0, 16'hFBFF, "R6");
    send(32'hC7C35000, 3'd1, 16'hFC00, "R6");
    send(32'hC7C35000, 3'd2, 16'hFBFF, "R6");
    send(32'hC7C35000, 3'd4, 16'hFC00, "R6");
    // R7 subnormals
    send(32'h33800000, 3'd3, 16'h0001, "R7");
    send(32'h33000000, 3'd3, 16'h0000, "R7");
    send(32'h33000000, 3'd4, 16'h0001, "R7");
    send(32'h33000000, 3'd0, 16'h0001, "R7");
    send(32'hB3000000, 3'd1, 16'h8001, "R7");
    send(32'h387FC000, 3'd2, 16'h03FF, "R7");
    send(32'h387FE000, 3'd3, 16'h0400, "R7");
    // R8 tiny
    send(32'h00000001, 3'd0, 16'h0001, "R8");
    send(32'h00000001, 3'd1, 16'h0000, "R8");
    send(32'h80000001, 3'd1, 16'h8001, "R8");
    send(32'h80000000, 3'd1, 16'h8000, "R8");
    send(32'h00000000, 3'd0, 16'h0000, "R8");
    send(32'h32FFFFFF, 3'd4, 16'h0000, "R8");
    send(32'h32FFFFFF, 3'd0, 16'h0001, "R8");
    // R9 specials
    send(32'h7F800001, 3'd3, 16'h7E00, "R9");
    send(32'hFFC00000, 3'd2, 16'hFE00, "R9");
    send(32'h7F800000, 3'd1, 16'h7C00, "R9");
    send(32'hFF800000, 3'd0, 16'hFC00, "R9");
    send(32'h7FFFE000, 3'd3, 16'h7FFF, "R9");
    // R1 alias codes
    send(32'h3F801000, 3'd5, 16'h3C00, "R1");
    send(32'h3F801000, 3'd7, 16'h3C00, "R1");
    send(32'h3F803000, 3'd6, 16'h3C02, "R1");
    idle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op;
      logic [2:0]  md;
      op = $urandom;
      if (i % 2 == 0) op[30:23] = 8'(100 + $urandom_range(0, 46));
      md = 3'($urandom_range(0, 7));
      send(op, md, ref_cvt(op, md), tag_of(op, md));
      if (i % 97 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    check("R11", 16'(exp_q.size()), 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule